// File: doc/BRIEF.md
# Buffered Serial Transceiver with Programmable Bit-Rate Divider

This block is a byte-wide asynchronous serial transceiver behind a small CPU register interface. Bytes written by the CPU are sent on `txd` as framed serial characters. Characters that arrive on `rxd` are turned back into bytes for the CPU to read. A 16-bit divider turns the system clock into a tick at sixteen times the bit rate. The transmitter and the receiver both run from that tick.

After reset each direction has a single holding slot. Setting one control bit gives each direction a 16-entry queue. Every receive entry stores three error flags next to its byte, so an error is reported with the character it belongs to. A status register can be read at any time without side effects on the data. One interrupt output combines three causes. Each cause has its own enable bit, and an identification register reports the most urgent pending cause.

Register map, selected by `addr`:

| addr | Write | Read |
|------|-------|------|
| 0 | push a byte for transmission | pop the head receive byte |
| 1 | interrupt enables | interrupt enables |
| 2 | queue control | interrupt identification |
| 3 | character format | character format |
| 4 | divisor, low byte | divisor, low byte |
| 5 | divisor, high byte | divisor, high byte |
| 6 | (no effect) | status |

Top module: `uart_fifo_core`

## Requirements
- R1: After reset the status register (addr 6) reads 0x60, the identification register (addr 2) reads 0x01, `irq` is low and `txd` is high. Status bits are: bit0 receive data ready, bit1 overrun, bit2 parity error of the head entry, bit3 framing error of the head entry, bit4 break of the head entry, bit5 transmit queue empty, bit6 transmitter completely idle.
- R2: With addr 2 bit0 clear (single mode, the reset state), each direction holds one byte. A second received character that arrives before the first is read is lost, and the first one stays readable.
- R3: With addr 2 bit0 set (queued mode), each direction buffers 16 bytes in arrival order. A 17th received character that arrives while the queue is full is discarded.
- R4: Every receive entry carries its own parity-error, framing-error and break flags. Status bits 2 to 4 report the flags of the entry currently at the head of the queue.
- R5: The divisor {addr5, addr4} sets one tick every divisor clocks. One serial bit lasts 16 ticks, in both directions.
- R6: A divisor of 0 behaves as a divisor of 1.
- R7: A character is sent as a low start bit, 8 data bits with the least significant bit first, an optional parity bit and a high stop bit. In addr 3, bit0 enables parity and bit1 selects odd parity (clear selects even).
- R8: The receiver starts a character on a falling edge of `rxd` and confirms it on the 8th tick. A low pulse shorter than 8 ticks produces no character. Each later bit is sampled 16 ticks after the previous sample.
- R9: A stop bit sampled low sets the framing-error flag. If the data bits, the parity bit and the stop bit are all low, the break flag is also set.
- R10: The overrun flag (status bit1) is set when a character is discarded because the queue is full. It stays set until the status register is read.
- R11: The addr 1 enable bits are: bit0 receive data ready, bit1 transmit queue empty, bit2 line error (overrun, or an error flag on the head entry). `irq` is high when any enabled cause is pending. The identification register reads 0x06 for a line error, 0x04 for data ready, 0x02 for transmit empty and 0x01 when nothing is pending, and the first matching cause in that order wins.
- R12: Reading the status register does not change the contents of either queue.
- R13: A write to addr 2 with bit1 set empties the receive queue. A write with bit2 set empties the transmit queue. Each one affects only its own queue. Changing bit0 (the mode) empties both queues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| wrEn | input | 1 | register write strobe |
| rdEn | input | 1 | register read strobe (pops on addr 0) |
| addr | input | 3 | register select |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational from addr |
| irq | output | 1 | interrupt request |
| txd | output | 1 | serial output, idles high |
| rxd | input | 1 | serial input, asynchronous |

## Verification
The transmitter can take a byte out of its queue in the same cycle that the CPU pushes a new one. The bench provokes this by writing a burst of 16 bytes while the serial capture of the first frame is already running. It judges the result by decoding every frame on `txd` and comparing the bytes, in order, with the bytes written. A second overlap is a status read that falls next to a character arriving. Reading the status several times while bytes are queued must leave each byte and its error flags unchanged.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_IEN   = 3'd1;
  localparam logic [2:0] ADDR_QCTL  = 3'd2;
  localparam logic [2:0] ADDR_FMT   = 3'd3;
  localparam logic [2:0] ADDR_DIVLO = 3'd4;
  localparam logic [2:0] ADDR_DIVHI = 3'd5;
  localparam logic [2:0] ADDR_STAT  = 3'd6;

  localparam logic [2:0] ID_NONE = 3'b001;
  localparam logic [2:0] ID_LINE = 3'b110;
  localparam logic [2:0] ID_RX   = 3'b100;
  localparam logic [2:0] ID_TX   = 3'b010;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic        txPush;
    logic [7:0]  txData;
    logic        rxPop;
    logic        clrRx;
    logic        clrTx;
    logic        fifoEn;
    logic        parEn;
    logic        parOdd;
    logic [15:0] divisor;
  } ctrlStrobe_t;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic     rxAvail;
    rxEntry_t rxHead;
    logic     txEmpty;
    logic     txIdle;
    logic     overrun;
  } dpStatus_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             singleMode,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = singleMode ? !empty : (count == CW'(DEPTH));
  assign doPush = push && !full && !clr;
  assign doPop  = pop && !empty && !clr;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/uart_dp.sv
module uart_dp
  import uart_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t cs,
  input  logic        rxd,
  output logic        txd,
  output dpStatus_t   st,
  output logic        baudTick,
  output logic [$clog2(DEPTH):0] rxCount,
  output logic [$clog2(DEPTH):0] txCount
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

  // baud tick
  logic [15:0] divCnt, divEff;
  assign divEff   = (cs.divisor == 16'd0) ? 16'd1 : cs.divisor;
  assign baudTick = (divCnt >= divEff - 16'd1);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= baudTick ? 16'd0 : divCnt + 16'd1;
  end

  // transmit queue and shifter
  logic [7:0]  txHead;
  logic        txEmpty, txFull, txPop, txBusy;
  logic [10:0] txSh, txFrame;
  logic [3:0]  txSub, txLeft;

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .clr(cs.clrTx), .singleMode(!cs.fifoEn),
    .push(cs.txPush), .din(cs.txData), .pop(txPop), .dout(txHead),
    .empty(txEmpty), .full(txFull), .count(txCount));

  assign txPop   = !txBusy && baudTick && !txEmpty;
  assign txFrame = cs.parEn ? {1'b1, (^txHead) ^ cs.parOdd, txHead, 1'b0}
                            : {2'b11, txHead, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txSh   <= '1;
      txSub  <= '0;
      txLeft <= '0;
    end else if (txPop) begin
      txBusy <= 1'b1;
      txSh   <= txFrame;
      txSub  <= '0;
      txLeft <= cs.parEn ? 4'd11 : 4'd10;
    end else if (txBusy && baudTick) begin
      txSub <= txSub + 4'd1;
      if (txSub == 4'd15) begin
        txSh   <= {1'b1, txSh[10:1]};
        txLeft <= txLeft - 4'd1;
        if (txLeft == 4'd1) txBusy <= 1'b0;
      end
    end
  end
  assign txd = txBusy ? txSh[0] : 1'b1;

  // receiver
  rxState_t rxState;
  logic     rxMeta, rxSync, rxPrev;
  logic [3:0] rxSub, rxIdx, lastIdx;
  logic [8:0] rxSh;
  logic       rxPush, rxEmpty, rxFull, parBit;
  rxEntry_t   rxNew, rxOut;

  assign lastIdx = cs.parEn ? 4'd9 : 4'd8;
  assign parBit  = cs.parEn ? rxSh[8] : 1'b0;
  assign rxPush  = (rxState == RX_BITS) && baudTick && (rxSub == 4'd15) && (rxIdx == lastIdx);
  always_comb begin
    rxNew.data = rxSh[7:0];
    rxNew.pe   = cs.parEn && (((^rxSh[7:0]) ^ parBit) != cs.parOdd);
    rxNew.fe   = !rxSync;
    rxNew.brk  = !rxSync && (rxSh[7:0] == 8'd0) && !parBit;
  end

  uart_fifo #(.WIDTH(11), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .clr(cs.clrRx), .singleMode(!cs.fifoEn),
    .push(rxPush), .din(rxNew), .pop(cs.rxPop), .dout(rxOut),
    .empty(rxEmpty), .full(rxFull), .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxPrev  <= 1'b1;
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxIdx   <= '0;
      rxSh    <= '0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      case (rxState)
        RX_IDLE: if (rxPrev && !rxSync) begin
          rxState <= RX_START;
          rxSub   <= '0;
        end
        RX_START: if (baudTick) begin
          if (rxSub == 4'd7) begin
            rxState <= rxSync ? RX_IDLE : RX_BITS;
            rxSub   <= '0;
            rxIdx   <= '0;
          end else rxSub <= rxSub + 4'd1;
        end
        default: if (baudTick) begin
          rxSub <= rxSub + 4'd1;
          if (rxSub == 4'd15) begin
            if (rxIdx == lastIdx) rxState <= RX_IDLE;
            else begin
              rxSh[rxIdx] <= rxSync;
              rxIdx       <= rxIdx + 4'd1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    st.rxAvail = !rxEmpty;
    st.rxHead  = rxEmpty ? '0 : rxOut;
    st.txEmpty = txEmpty;
    st.txIdle  = txEmpty && !txBusy;
    st.overrun = rxPush && rxFull && !cs.clrRx;
  end
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  dpStatus_t   st,
  output logic [7:0]  rdata,
  output logic        irq,
  output ctrlStrobe_t cs
);
  logic [2:0]  ien, irqId;
  logic        fifoEn, parEn, parOdd, ovrFlag, lineErr, qctlWr;
  logic [15:0] divisor;
  logic [2:0]  pending;

  assign qctlWr = wrEn && (addr == ADDR_QCTL);

  always_comb begin
    cs.txPush  = wrEn && (addr == ADDR_DATA);
    cs.txData  = wdata;
    cs.rxPop   = rdEn && (addr == ADDR_DATA);
    cs.clrRx   = qctlWr && (wdata[1] || (wdata[0] != fifoEn));
    cs.clrTx   = qctlWr && (wdata[2] || (wdata[0] != fifoEn));
    cs.fifoEn  = fifoEn;
    cs.parEn   = parEn;
    cs.parOdd  = parOdd;
    cs.divisor = divisor;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ien     <= '0;
      fifoEn  <= 1'b0;
      parEn   <= 1'b0;
      parOdd  <= 1'b0;
      divisor <= 16'd1;
      ovrFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          ADDR_IEN:   ien           <= wdata[2:0];
          ADDR_QCTL:  fifoEn        <= wdata[0];
          ADDR_FMT:   {parOdd, parEn} <= wdata[1:0];
          ADDR_DIVLO: divisor[7:0]  <= wdata;
          ADDR_DIVHI: divisor[15:8] <= wdata;
          default: ;
        endcase
      end
      if (st.overrun) ovrFlag <= 1'b1;
      else if (rdEn && addr == ADDR_STAT) ovrFlag <= 1'b0;
    end
  end

  assign lineErr = ovrFlag || (st.rxAvail && (st.rxHead.pe || st.rxHead.fe || st.rxHead.brk));
  assign pending = ien & {lineErr, st.txEmpty, st.rxAvail};
  assign irq     = |pending;

  always_comb begin
    if (pending[2])      irqId = ID_LINE;
    else if (pending[0]) irqId = ID_RX;
    else if (pending[1]) irqId = ID_TX;
    else                 irqId = ID_NONE;
  end

  always_comb begin
    case (addr)
      ADDR_DATA:  rdata = st.rxHead.data;
      ADDR_IEN:   rdata = {5'd0, ien};
      ADDR_QCTL:  rdata = {5'd0, irqId};
      ADDR_FMT:   rdata = {6'd0, parOdd, parEn};
      ADDR_DIVLO: rdata = divisor[7:0];
      ADDR_DIVHI: rdata = divisor[15:8];
      ADDR_STAT:  rdata = {1'b0, st.txIdle, st.txEmpty, st.rxHead.brk, st.rxHead.fe,
                           st.rxHead.pe, ovrFlag, st.rxAvail};
      default:    rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       txd,
  input  logic       rxd
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  ctrlStrobe_t   cs;
  dpStatus_t     st;
  logic          baudTick;
  logic [CW-1:0] rxCount, txCount;

  uart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .st(st), .rdata(rdata), .irq(irq), .cs(cs));

  uart_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .rxd(rxd), .txd(txd), .st(st),
    .baudTick(baudTick), .rxCount(rxCount), .txCount(txCount));
endmodule

// File: rtl/uart_fifo_core_chk.sv
module uart_fifo_core_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        fifoEn,
  input logic [15:0] divisor,
  input logic        baudTick,
  input logic [$clog2(DEPTH):0] rxCount,
  input logic [$clog2(DEPTH):0] txCount
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_rx_capacity_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CW'(DEPTH) && txCount <= CW'(DEPTH));

  assert_single_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> (rxCount <= CW'(1) && txCount <= CW'(1)));

  assert_status_read_keeps_rx_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd6 && !wrEn) |=> rxCount >= $past(rxCount));

  assert_div_zero_ticks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (divisor <= 16'd1) |-> baudTick);

  assert_clear_tx_R13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && wdata[2]) |=> txCount == '0);
endmodule

bind uart_fifo_core uart_fifo_core_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
  .fifoEn(cs.fifoEn), .divisor(cs.divisor), .baudTick(baudTick),
  .rxCount(rxCount), .txCount(txCount));

// File: tb/test_uart_fifo_core.sv
module test_uart_fifo_core;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rxd = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, txd;
  int checks = 0, fails = 0, bitClk = 16;
  bit curPen = 0, curOdd = 0;

  always #5 clk = ~clk;

  uart_fifo_core i_uart_fifo_core (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd));

  function automatic logic [7:0] expStat(bit rdy, bit ovr, bit pe, bit fe, bit brk, bit txE, bit txI);
    return {1'b0, txI, txE, brk, fe, pe, ovr, rdy};
  endfunction

  function automatic bit parOf(logic [7:0] b, bit odd);
    return (^b) ^ odd;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setDiv(input logic [15:0] dv);
    wrReg(3'd4, dv[7:0]); wrReg(3'd5, dv[15:8]);
    bitClk = 16 * ((dv == 16'd0) ? 1 : int'(dv));
  endtask

  task automatic setFmt(input bit pen, input bit odd);
    curPen = pen; curOdd = odd; wrReg(3'd3, {6'd0, odd, pen});
  endtask

  task automatic holdBit(input logic v);
    rxd = v; repeat (bitClk) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit badPar, input bit badStop, input bit isBrk);
    @(negedge clk);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(isBrk ? 1'b0 : b[i]);
    if (curPen) holdBit(isBrk ? 1'b0 : (parOf(b, curOdd) ^ badPar));
    holdBit((badStop || isBrk) ? 1'b0 : 1'b1);
    holdBit(1'b1);
  endtask

  task automatic getTx(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    logic pb, sb, st0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bitClk / 2) @(negedge clk);
    st0 = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (bitClk) @(negedge clk);
      got[i] = txd;
    end
    pb = parOf(exp, curOdd);
    if (curPen) begin repeat (bitClk) @(negedge clk); pb = txd; end
    repeat (bitClk) @(negedge clk);
    sb = txd;
    check({tag, " start"}, st0, 1'b0);
    check({tag, " data"}, got, exp);
    check({tag, " parity"}, pb, parOf(exp, curOdd));
    check({tag, " stop"}, sb, 1'b1);
  endtask

  task automatic runAll();
    logic [7:0] v, a, b;
    logic [7:0] q [16];
    // R1 reset state
    rdReg(3'd6, v); check("R1 status", v, 8'h60);
    rdReg(3'd2, v); check("R1 id", v, 8'h01);
    check("R1 irq", irq, 1'b0);
    check("R1 txd", txd, 1'b1);
    setDiv(16'd2); setFmt(0, 0);

    // R2 / R10 single mode overrun
    a = 8'hA5; b = 8'h3C;
    sendByte(a, 0, 0, 0); sendByte(b, 0, 0, 0);
    rdReg(3'd6, v); check("R2 R10 status overrun", v, expStat(1,1,0,0,0,1,1));
    rdReg(3'd0, v); check("R2 first kept", v, a);
    rdReg(3'd6, v); check("R10 overrun cleared, second dropped", v, 8'h60);

    // R7 R5 single tx
    wrReg(3'd0, 8'h96); getTx("R7 single tx", 8'h96);

    // R3 queued mode, random format
    wrReg(3'd2, 8'h01);
    setFmt(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    for (int i = 0; i < 16; i++) begin
      q[i] = 8'($urandom());
      sendByte(q[i], 0, 0, 0);
    end
    sendByte(8'h77, 0, 0, 0);
    rdReg(3'd6, v); check("R3 R10 full then overrun", v, expStat(1,1,0,0,0,1,1));
    for (int i = 0; i < 16; i++) begin
      rdReg(3'd0, v); check("R3 rx order", v, q[i]);
    end
    rdReg(3'd6, v); check("R3 17th discarded", v, 8'h60);

    // R3 R7 tx burst while shifting
    for (int i = 0; i < 16; i++) q[i] = 8'($urandom());
    fork
      for (int i = 0; i < 16; i++) wrReg(3'd0, q[i]);
      for (int i = 0; i < 16; i++) getTx("R3 R7 tx burst", q[i]);
    join
    repeat (bitClk) @(negedge clk);

    // R4 R9 error flags travel with bytes, even parity
    setFmt(1, 0);
    sendByte(8'h5A, 1, 0, 0);
    sendByte(8'h33, 0, 1, 0);
    sendByte(8'h00, 0, 0, 1);
    sendByte(8'h81, 0, 0, 0);
    rdReg(3'd6, v); check("R4 parity err head", v, expStat(1,0,1,0,0,1,1));
    rdReg(3'd0, v); check("R4 byte with pe", v, 8'h5A);
    rdReg(3'd6, v); check("R9 framing err head", v, expStat(1,0,0,1,0,1,1));
    rdReg(3'd0, v); check("R9 byte with fe", v, 8'h33);
    rdReg(3'd6, v); check("R9 break head", v, expStat(1,0,0,1,1,1,1));
    rdReg(3'd0, v); check("R9 break byte", v, 8'h00);
    rdReg(3'd6, v); check("R4 clean head", v, expStat(1,0,0,0,0,1,1));
    rdReg(3'd0, v); check("R4 clean byte", v, 8'h81);

    // R8 glitch rejected
    @(negedge clk); rxd = 1'b0; repeat (bitClk / 4) @(negedge clk); rxd = 1'b1;
    repeat (12 * bitClk) @(negedge clk);
    rdReg(3'd6, v); check("R8 glitch ignored", v, 8'h60);

    // R11 interrupts and priority
    wrReg(3'd1, 8'h00); check("R11 all disabled", irq, 1'b0);
    wrReg(3'd1, 8'h02); check("R11 tx empty irq", irq, 1'b1);
    rdReg(3'd2, v); check("R11 id tx", v, 8'h02);
    wrReg(3'd1, 8'h01); check("R11 rx disabled cause idle", irq, 1'b0);
    sendByte(8'h42, 0, 0, 0);
    check("R11 rx irq", irq, 1'b1);
    wrReg(3'd1, 8'h03); rdReg(3'd2, v); check("R11 rx over tx", v, 8'h04);
    sendByte(8'h24, 0, 1, 0);
    wrReg(3'd1, 8'h07); rdReg(3'd2, v); check("R11 clean head id", v, 8'h04);
    rdReg(3'd0, v); rdReg(3'd2, v); check("R11 line over rx", v, 8'h06);
    rdReg(3'd0, v); rdReg(3'd2, v); check("R11 back to tx", v, 8'h02);
    wrReg(3'd1, 8'h00);

    // R12 status reads do not disturb
    sendByte(8'hC3, 0, 0, 0); sendByte(8'h1E, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      rdReg(3'd6, v); check("R12 repeated status", v, expStat(1,0,0,0,0,1,1));
    end
    rdReg(3'd0, v); check("R12 first intact", v, 8'hC3);
    rdReg(3'd0, v); check("R12 second intact", v, 8'h1E);

    // R13 independent clears
    sendByte(8'h11, 0, 0, 0); sendByte(8'h22, 0, 0, 0);
    for (int i = 0; i < 4; i++) wrReg(3'd0, 8'(i + 1));
    wrReg(3'd2, 8'h03);
    rdReg(3'd6, v); check("R13 rx cleared tx kept", v, 8'h00);
    wrReg(3'd2, 8'h05);
    rdReg(3'd6, v); check("R13 tx cleared", v, 8'h20);
    repeat (13 * bitClk) @(negedge clk);
    sendByte(8'h66, 0, 0, 0);
    wrReg(3'd2, 8'h00);
    rdReg(3'd6, v); check("R13 mode change clears", v, 8'h60);

    // R5 R6 other divisors
    setFmt(0, 0);
    setDiv(16'd0); wrReg(3'd0, 8'h5C); getTx("R6 divisor zero", 8'h5C);
    repeat (bitClk) @(negedge clk);
    setDiv(16'd3); wrReg(3'd0, 8'hE7); getTx("R5 divisor three", 8'hE7);
    sendByte(8'h9B, 0, 0, 0);
    rdReg(3'd0, v); check("R5 rx at divisor three", v, 8'h9B);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule